// File: doc/BRIEF.md
# Two-Level Command Chaining Queue

This block sits between a host and the protocol engine of a token-passing network controller. It holds transmit and receive commands, so that the host can post a second command while the first one is still waiting or running. Each direction has a two-entry command FIFO. A transmit entry holds a buffer page number. A receive entry holds a page number and a broadcast-accept flag. Each direction also has its own two-entry queue of completion status. The host reads this status through level outputs and releases it with explicit clear commands.

The engine sees the head command of each queue on a request output. It reports that it has begun a command with a start pulse, and that the command has finished with a done pulse. The done pulse pops the command and pushes a status entry. When chaining is disabled, each command queue keeps only one entry, which gives the older single-buffer behaviour. Cancel commands remove queued work that has not yet begun. Work that is already running is never removed.

Top module: `cmd_chain_queue`

## Requirements
- R1: After reset, both command and status queues are empty. tx_req_o and rx_req_o are 0, tx_avail_o and rx_inhib_o are 1, both interrupt lines are 0, and both overflow flags are 0.
- R2: Host opcodes on cmd_op_i (acted on when cmd_valid_i=1) are: 1 queue transmit, 2 queue receive, 3 cancel transmit, 4 cancel receive, 5 clear transmit status, 6 clear receive status, 7 clear overflow flags; 0 does nothing. With chain_en_i=1, two commands per direction are held and issued oldest first. The head page appears on tx_page_o or rx_page_o. The req output is 1 while the head has not been started.
- R3: With chaining on, a queue command written while its queue holds two entries is dropped. The direction's sticky overflow flag is set, and it stays set until opcode 7.
- R4: With chain_en_i=0 the command depth is one. A new command replaces a pending head that has not started. If the head has started, the new command is dropped and the overflow flag is set.
- R5: Cancel receive removes the oldest reception that has not started. If the head has started, the head is kept and the second entry is removed.
- R6: Two successive cancel-receive commands remove two unstarted queued receptions, leaving the receive queue empty.
- R7: Cancel transmit removes every transmit that has not started. When no transmit is running, tx_avail_o is 1 afterwards.
- R8: A done pulse for a started head pops it and pushes a status entry. For transmit, the entry holds tx_ack_i. For receive, it holds the completed entry's broadcast flag. While a status entry is present, the interrupt line for that direction is 1 and tx_avail_o or rx_inhib_o is 1. tx_acked_o and rx_done_bc_o show the head entry.
- R9: Clear-status opcodes pop the oldest status entry. A second queued entry shows on the outputs in the next cycle.
- R10: With chaining on, a queue command that arrives in the same cycle as the done pulse for a full queue is accepted, and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_en_i | input | 1 | 1 = two-deep chaining, 0 = single-entry mode |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 3 | Host opcode |
| cmd_page_i | input | PAGE_W | Page number for queue commands |
| cmd_bcast_i | input | 1 | Broadcast-accept flag for receive commands |
| tx_start_i | input | 1 | Engine has begun the transmit head |
| tx_done_i | input | 1 | Engine finished the transmit head |
| tx_ack_i | input | 1 | Transmit was acknowledged (with tx_done_i) |
| rx_start_i | input | 1 | Engine has begun the receive head |
| rx_done_i | input | 1 | Engine finished the receive head |
| tx_req_o | output | 1 | Unstarted transmit head waiting |
| tx_page_o | output | PAGE_W | Transmit head page |
| rx_req_o | output | 1 | Unstarted receive head waiting |
| rx_page_o | output | PAGE_W | Receive head page |
| rx_bcast_o | output | 1 | Receive head broadcast flag |
| tx_avail_o | output | 1 | Transmit status pending or no transmit queued |
| tx_acked_o | output | 1 | Head transmit status was acknowledged |
| tx_irq_o | output | 1 | Transmit status pending |
| rx_inhib_o | output | 1 | Receive status pending or no reception queued |
| rx_done_bc_o | output | 1 | Broadcast flag of head receive status |
| rx_irq_o | output | 1 | Receive status pending |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_ovf_o | output | 1 | Sticky receive overflow |

## Verification
Two events can fall in the same cycle and compete for one command slot: the host queues a command, and the engine completes the head of an already full queue. The bench fills the transmit queue and starts its head. In one cycle it then drives the done pulse and a queue-transmit opcode together. It judges the result from the ports: the overflow flag must stay clear, the interrupt must rise with the acknowledged status, and after the second command completes, the page written in that shared cycle must come to the head.

// File: rtl/cmd_chain_pkg.sv
package cmd_chain_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_TX_Q    = 3'd1,
    OP_RX_Q    = 3'd2,
    OP_TX_CAN  = 3'd3,
    OP_RX_CAN  = 3'd4,
    OP_TX_CLR  = 3'd5,
    OP_RX_CLR  = 3'd6,
    OP_OVF_CLR = 3'd7
  } cmd_op_e;

  localparam int unsigned QDEPTH = 2;
  localparam int unsigned CNT_W  = $clog2(QDEPTH + 1);
endpackage

// File: rtl/cmd_fifo2.sv
module cmd_fifo2
  import cmd_chain_pkg::*;
#(
  parameter int unsigned W          = 2,
  parameter bit          CANCEL_ALL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             limit1_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             cancel_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             started_o,
  output logic             popped_o,
  output logic             drop_o
);
  logic [W-1:0]     s0_q, s1_q, s0_d, s1_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             st_q, st_d;

  always_comb begin
    s0_d = s0_q; s1_d = s1_q; cnt_d = cnt_q; st_d = st_q;
    drop_o = 1'b0; popped_o = 1'b0;
    lim = limit1_i ? CNT_W'(1) : CNT_W'(QDEPTH);
    // completion retires the running head
    if (done_i && cnt_q != '0 && st_q) begin
      s0_d = s1_q; cnt_d = cnt_q - 1'b1; st_d = 1'b0; popped_o = 1'b1;
    end
    // cancel never touches a started head
    if (cancel_i && cnt_d != '0) begin
      if (st_d) begin
        if (cnt_d == CNT_W'(QDEPTH)) cnt_d = CNT_W'(1);
      end else if (CANCEL_ALL) begin
        cnt_d = '0;
      end else begin
        s0_d = s1_d; cnt_d = cnt_d - 1'b1;
      end
    end
    if (push_i) begin
      if (cnt_d < lim) begin
        if (cnt_d == '0) s0_d = data_i;
        else             s1_d = data_i;
        cnt_d = cnt_d + 1'b1;
      end else if (limit1_i && !st_d) begin
        s0_d = data_i;
      end else begin
        drop_o = 1'b1;
      end
    end
    if (start_i && cnt_d != '0 && !st_d) st_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0; s1_q <= '0; cnt_q <= '0; st_q <= 1'b0;
    end else begin
      s0_q <= s0_d; s1_q <= s1_d; cnt_q <= cnt_d; st_q <= st_d;
    end
  end

  assign head_o    = s0_q;
  assign count_o   = cnt_q;
  assign started_o = st_q;
endmodule

// File: rtl/stat_fifo2.sv
module stat_fifo2
  import cmd_chain_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         valid_o,
  output logic         drop_o
);
  logic [W-1:0]     s0_q, s1_q, s0_d, s1_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    s0_d = s0_q; s1_d = s1_q; cnt_d = cnt_q; drop_o = 1'b0;
    if (pop_i && cnt_q != '0) begin
      s0_d = s1_q; cnt_d = cnt_q - 1'b1;
    end
    if (push_i) begin
      if (cnt_d < CNT_W'(QDEPTH)) begin
        if (cnt_d == '0) s0_d = data_i;
        else             s1_d = data_i;
        cnt_d = cnt_d + 1'b1;
      end else begin
        drop_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0; s1_q <= '0; cnt_q <= '0;
    end else begin
      s0_q <= s0_d; s1_q <= s1_d; cnt_q <= cnt_d;
    end
  end

  assign head_o  = s0_q;
  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/cmd_chain_queue.sv
module cmd_chain_queue
  import cmd_chain_pkg::*;
#(
  parameter int unsigned PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chain_en_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [PAGE_W-1:0] cmd_page_i,
  input  logic              cmd_bcast_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              tx_ack_i,
  input  logic              rx_start_i,
  input  logic              rx_done_i,
  output logic              tx_req_o,
  output logic [PAGE_W-1:0] tx_page_o,
  output logic              rx_req_o,
  output logic [PAGE_W-1:0] rx_page_o,
  output logic              rx_bcast_o,
  output logic              tx_avail_o,
  output logic              tx_acked_o,
  output logic              tx_irq_o,
  output logic              rx_inhib_o,
  output logic              rx_done_bc_o,
  output logic              rx_irq_o,
  output logic              tx_ovf_o,
  output logic              rx_ovf_o
);
  localparam int unsigned RXW = PAGE_W + 1;

  cmd_op_e op;
  assign op = cmd_valid_i ? cmd_op_e'(cmd_op_i) : OP_NOP;

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_st, rx_st, tx_pop, rx_pop, tx_drop, rx_drop;
  logic             txs_valid, rxs_valid, txs_drop, rxs_drop;
  logic [RXW-1:0]   rx_head;
  logic             tx_ovf_q, rx_ovf_q;

  cmd_fifo2 #(.W(PAGE_W), .CANCEL_ALL(1'b1)) u_tx_q (
    .clk_i, .rst_ni,
    .limit1_i (!chain_en_i),
    .push_i   (op == OP_TX_Q),
    .data_i   (cmd_page_i),
    .start_i  (tx_start_i),
    .done_i   (tx_done_i),
    .cancel_i (op == OP_TX_CAN),
    .head_o   (tx_page_o),
    .count_o  (tx_cnt),
    .started_o(tx_st),
    .popped_o (tx_pop),
    .drop_o   (tx_drop)
  );

  cmd_fifo2 #(.W(RXW), .CANCEL_ALL(1'b0)) u_rx_q (
    .clk_i, .rst_ni,
    .limit1_i (!chain_en_i),
    .push_i   (op == OP_RX_Q),
    .data_i   ({cmd_bcast_i, cmd_page_i}),
    .start_i  (rx_start_i),
    .done_i   (rx_done_i),
    .cancel_i (op == OP_RX_CAN),
    .head_o   (rx_head),
    .count_o  (rx_cnt),
    .started_o(rx_st),
    .popped_o (rx_pop),
    .drop_o   (rx_drop)
  );

  stat_fifo2 #(.W(1)) u_tx_stat (
    .clk_i, .rst_ni,
    .push_i (tx_pop),
    .data_i (tx_ack_i),
    .pop_i  (op == OP_TX_CLR),
    .head_o (tx_acked_o),
    .valid_o(txs_valid),
    .drop_o (txs_drop)
  );

  stat_fifo2 #(.W(1)) u_rx_stat (
    .clk_i, .rst_ni,
    .push_i (rx_pop),
    .data_i (rx_head[RXW-1]),
    .pop_i  (op == OP_RX_CLR),
    .head_o (rx_done_bc_o),
    .valid_o(rxs_valid),
    .drop_o (rxs_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ovf_q <= 1'b0; rx_ovf_q <= 1'b0;
    end else if (op == OP_OVF_CLR) begin
      tx_ovf_q <= 1'b0; rx_ovf_q <= 1'b0;
    end else begin
      if (tx_drop || txs_drop) tx_ovf_q <= 1'b1;
      if (rx_drop || rxs_drop) rx_ovf_q <= 1'b1;
    end
  end

  assign tx_req_o   = (tx_cnt != '0) && !tx_st;
  assign rx_req_o   = (rx_cnt != '0) && !rx_st;
  assign rx_page_o  = rx_head[PAGE_W-1:0];
  assign rx_bcast_o = rx_head[RXW-1];
  assign tx_irq_o   = txs_valid;
  assign rx_irq_o   = rxs_valid;
  assign tx_avail_o = txs_valid || (tx_cnt == '0);
  assign rx_inhib_o = rxs_valid || (rx_cnt == '0);
  assign tx_ovf_o   = tx_ovf_q;
  assign rx_ovf_o   = rx_ovf_q;
endmodule

// File: rtl/cmd_chain_queue_chk.sv
module cmd_chain_queue_chk
  import cmd_chain_pkg::*;
#(
  parameter int unsigned CW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chain_en_i,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic          tx_done_i,
  input logic          rx_done_i,
  input logic          tx_req_o,
  input logic          rx_req_o,
  input logic          tx_avail_o,
  input logic          tx_irq_o,
  input logic          rx_irq_o,
  input logic          tx_ovf_o,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  logic tx_q_cmd, rx_q_cmd, tx_can_cmd, rx_can_cmd, ovf_clr_cmd;
  assign tx_q_cmd    = cmd_valid_i && cmd_op_i == 3'd1;
  assign rx_q_cmd    = cmd_valid_i && cmd_op_i == 3'd2;
  assign tx_can_cmd  = cmd_valid_i && cmd_op_i == 3'd3;
  assign rx_can_cmd  = cmd_valid_i && cmd_op_i == 3'd4;
  assign ovf_clr_cmd = cmd_valid_i && cmd_op_i == 3'd7;

  // R3
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_o && !ovf_clr_cmd) |=> tx_ovf_o);

  // R4
  legacy_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_en_i && tx_cnt <= CW'(1) && tx_q_cmd) |=> (tx_cnt == CW'(1)));

  // R5
  rx_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_can_cmd && rx_req_o && !rx_done_i) |=> (rx_cnt == $past(rx_cnt) - CW'(1)));

  // R7
  tx_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_can_cmd && tx_req_o) |=> tx_avail_o);

  // R8
  tx_done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !tx_req_o && tx_cnt != '0) |=> tx_irq_o);

  // R8
  rx_done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !rx_req_o && rx_cnt != '0) |=> rx_irq_o);

  // R10
  full_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_en_i && tx_q_cmd && tx_cnt == CW'(2) && tx_done_i && !tx_req_o)
      |=> (tx_cnt == CW'(2)));
endmodule

bind cmd_chain_queue cmd_chain_queue_chk #(.CW(cmd_chain_pkg::CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chain_en_i (chain_en_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .tx_done_i  (tx_done_i),
  .rx_done_i  (rx_done_i),
  .tx_req_o   (tx_req_o),
  .rx_req_o   (rx_req_o),
  .tx_avail_o (tx_avail_o),
  .tx_irq_o   (tx_irq_o),
  .rx_irq_o   (rx_irq_o),
  .tx_ovf_o   (tx_ovf_o),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt)
);

// File: tb/cmd_chain_queue_test.sv
`timescale 1ns/1ps
module cmd_chain_queue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chain_en = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_page = 2'd0;
  logic       cmd_bcast = 1'b0;
  logic       tx_start = 1'b0, tx_done = 1'b0, tx_ack = 1'b0;
  logic       rx_start = 1'b0, rx_done = 1'b0;
  logic       tx_req, rx_req, rx_bcast, tx_avail, tx_acked, tx_irq;
  logic       rx_inhib, rx_done_bc, rx_irq, tx_ovf, rx_ovf;
  logic [1:0] tx_page, rx_page;
  int         n_chk = 0, n_fail = 0;

  localparam logic [2:0] TXQ = 3'd1, RXQ = 3'd2, TXC = 3'd3, RXC = 3'd4;
  localparam logic [2:0] TXCLR = 3'd5, RXCLR = 3'd6, OVFCLR = 3'd7;

  always #2 clk = ~clk;

  cmd_chain_queue #(.PAGE_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_i(chain_en),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_page_i(cmd_page),
    .cmd_bcast_i(cmd_bcast),
    .tx_start_i(tx_start), .tx_done_i(tx_done), .tx_ack_i(tx_ack),
    .rx_start_i(rx_start), .rx_done_i(rx_done),
    .tx_req_o(tx_req), .tx_page_o(tx_page), .rx_req_o(rx_req),
    .rx_page_o(rx_page), .rx_bcast_o(rx_bcast), .tx_avail_o(tx_avail),
    .tx_acked_o(tx_acked), .tx_irq_o(tx_irq), .rx_inhib_o(rx_inhib),
    .rx_done_bc_o(rx_done_bc), .rx_irq_o(rx_irq),
    .tx_ovf_o(tx_ovf), .rx_ovf_o(rx_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst_n = 1'b0; chain_en = en;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] pg, input logic bc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; cmd_bcast = bc;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic eng(input logic ts, input logic td, input logic ta,
                     input logic rs, input logic rd);
    @(negedge clk);
    tx_start = ts; tx_done = td; tx_ack = ta; rx_start = rs; rx_done = rd;
    @(negedge clk);
    tx_start = 0; tx_done = 0; tx_ack = 0; rx_start = 0; rx_done = 0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_avail", tx_avail, 1);
    chk("R1 rx_inhib", rx_inhib, 1);
    chk("R1 irqs", {tx_irq, rx_irq}, 0);
    chk("R1 ovf", {tx_ovf, rx_ovf}, 0);
  endtask

  task automatic t_order();
    do_reset(1'b1);
    cmd(TXQ, 2'd1, 0);
    cmd(TXQ, 2'd2, 0);
    chk("R2 req", tx_req, 1);
    chk("R2 head page", tx_page, 1);
    chk("R2 avail low", tx_avail, 0);
    eng(1, 0, 0, 0, 0);
    chk("R2 started", tx_req, 0);
    eng(0, 1, 1, 0, 0);
    chk("R8 irq", tx_irq, 1);
    chk("R8 acked", tx_acked, 1);
    chk("R8 avail", tx_avail, 1);
    chk("R2 next page", tx_page, 2);
    chk("R2 next req", tx_req, 1);
    cmd(TXCLR, 0, 0);
    chk("R9 irq cleared", tx_irq, 0);
    chk("R9 avail low", tx_avail, 0);
    eng(1, 0, 0, 0, 0);
    eng(0, 1, 0, 0, 0);
    chk("R8 irq 2", tx_irq, 1);
    chk("R8 not acked", tx_acked, 0);
    cmd(TXCLR, 0, 0);
    chk("R9 empty avail", tx_avail, 1);
    chk("R9 irq 0", tx_irq, 0);
  endtask

  task automatic t_overflow();
    do_reset(1'b1);
    cmd(RXQ, 2'd1, 0);
    cmd(RXQ, 2'd2, 0);
    chk("R3 no ovf yet", rx_ovf, 0);
    cmd(RXQ, 2'd3, 0);
    chk("R3 ovf", rx_ovf, 1);
    chk("R3 tx ovf untouched", tx_ovf, 0);
    chk("R3 head kept", rx_page, 1);
    cmd(RXQ, 2'd0, 0);
    chk("R3 sticky", rx_ovf, 1);
    cmd(OVFCLR, 0, 0);
    chk("R3 cleared", rx_ovf, 0);
    cmd(RXC, 0, 0);
    chk("R3 second kept", rx_page, 2);
  endtask

  task automatic t_legacy();
    do_reset(1'b0);
    cmd(RXQ, 2'd1, 1);
    cmd(RXQ, 2'd2, 0);
    chk("R4 replaced page", rx_page, 2);
    chk("R4 replaced bcast", rx_bcast, 0);
    chk("R4 no ovf", rx_ovf, 0);
    eng(0, 0, 0, 1, 0);
    chk("R4 started", rx_req, 0);
    cmd(RXQ, 2'd3, 1);
    chk("R4 drop ovf", rx_ovf, 1);
    eng(0, 0, 0, 0, 1);
    chk("R4 dropped", rx_req, 0);
    chk("R8 rx irq", rx_irq, 1);
    chk("R8 rx bc", rx_done_bc, 0);
    cmd(TXQ, 2'd1, 0);
    cmd(TXQ, 2'd3, 0);
    chk("R4 tx replaced", tx_page, 3);
    chk("R4 tx no ovf", tx_ovf, 0);
  endtask

  task automatic t_rx_cancel();
    do_reset(1'b1);
    cmd(RXQ, 2'd1, 1);
    cmd(RXQ, 2'd2, 0);
    eng(0, 0, 0, 1, 0);
    cmd(RXC, 0, 0);
    chk("R5 started kept", rx_req, 0);
    chk("R5 head page", rx_page, 1);
    eng(0, 0, 0, 0, 1);
    chk("R5 irq", rx_irq, 1);
    chk("R8 rx bc", rx_done_bc, 1);
    chk("R5 second gone", rx_req, 0);
    cmd(RXCLR, 0, 0);
    chk("R5 empty inhib", rx_inhib, 1);
    cmd(RXQ, 2'd2, 0);
    cmd(RXQ, 2'd3, 0);
    cmd(RXC, 0, 0);
    chk("R5 oldest removed", rx_page, 3);
    chk("R5 req", rx_req, 1);
    cmd(RXC, 0, 0);
    chk("R6 both gone", rx_req, 0);
    chk("R6 inhib", rx_inhib, 1);
  endtask

  task automatic t_tx_cancel();
    do_reset(1'b1);
    cmd(TXQ, 2'd1, 0);
    cmd(TXQ, 2'd2, 0);
    cmd(TXC, 0, 0);
    chk("R7 avail", tx_avail, 1);
    chk("R7 req", tx_req, 0);
    cmd(TXQ, 2'd1, 0);
    eng(1, 0, 0, 0, 0);
    cmd(TXQ, 2'd2, 0);
    cmd(TXC, 0, 0);
    chk("R7 running kept", tx_avail, 0);
    eng(0, 1, 1, 0, 0);
    chk("R7 done irq", tx_irq, 1);
    cmd(TXCLR, 0, 0);
    chk("R7 nothing left", tx_req, 0);
    chk("R7 avail end", tx_avail, 1);
  endtask

  task automatic t_collision();
    do_reset(1'b1);
    cmd(TXQ, 2'd1, 0);
    cmd(TXQ, 2'd2, 0);
    eng(1, 0, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = TXQ; cmd_page = 2'd3;
    tx_done = 1'b1; tx_ack = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; tx_done = 1'b0; tx_ack = 1'b0;
    chk("R10 no ovf", tx_ovf, 0);
    chk("R10 head", tx_page, 2);
    chk("R10 irq", tx_irq, 1);
    eng(1, 0, 0, 0, 0);
    eng(0, 1, 0, 0, 0);
    chk("R10 third accepted", tx_page, 3);
    chk("R10 req", tx_req, 1);
    chk("R9 first acked", tx_acked, 1);
    cmd(TXCLR, 0, 0);
    chk("R9 second shown", tx_acked, 0);
    chk("R9 still irq", tx_irq, 1);
    cmd(TXCLR, 0, 0);
    chk("R9 drained", tx_irq, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_overflow();
    t_legacy();
    t_rx_cancel();
    t_tx_cancel();
    t_collision();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule